// File: doc/BRIEF.md
# Converter Start-up and Calibration Sequencer

This block owns the digital lifecycle of a stereo oversampling converter. An active-low reset that doubles as power-down holds the converter quiet. It clears the decimation filter and forces the serial outputs low. While forced, it gives the level at which the bit clock must rest, which is the polarity select. The reset pin is asynchronous: asserting it takes effect at once. Its release passes through a two-stage synchroniser, so every device that shares the master clock and the reset line leaves reset on the same edge.

After reset the sequencer qualifies start-up. When the device drives its own framing clocks, it goes straight into offset calibration. As a framing slave, it waits for the left/right clock to fall and then rise. In the slave variant where the word clock is an input, it instead waits for three word-clock/left-right-clock level states in a fixed order. Calibration lasts a fixed number of left/right clock rises (8192 by default). After that the run enable rises and stays high until the next reset. The framing inputs are synchronised with two flip-flops before any edge or level is evaluated.

Top module: `startup_seq`

## Requirements
- R1: While `rstN` is low, whether or not a clock edge has occurred, `runEn` and `calActive` are 0, and `outForce` and `filterClr` are 1.
- R2: While `outForce` is 1, `bitClkHold` equals `polSel`; while running, `bitClkHold` is 0.
- R3: After `rstN` rises, `filterClr` stays 1 through the third rising clock edge and is 0 after it.
- R4: With `slaveMode` = 0, `calActive` rises on that third rising edge after reset release, without any framing clock activity.
- R5: With `slaveMode` = 1 and `wcInMode` = 0, calibration starts only on the edge after a synchronised rise of `lrClkIn` that follows a synchronised fall of `lrClkIn`.
- R6: In that slave mode, static framing levels and a rise of `lrClkIn` before any fall have no effect: `calActive` stays 0 and `outForce` stays 1.
- R7: With `slaveMode` = 1 and `wcInMode` = 1, calibration starts only after the synchronised pair (wordClk, lrClk) has shown (1,1), then (1,0), then (1,1), in that order; while the word clock is low, the sequence does not advance.
- R8: Calibration ends on the edge after the CAL_PERIODS-th synchronised rise of `lrClkIn` counted from calibration entry; `runEn` then rises and `calActive` falls.
- R9: A reset during calibration abandons it; after release the full sequence, including the whole count, runs again.
- R10: Once high, `runEn` stays high until reset, and `outForce` is 0 while it is high.
- R11: `runEn`, `calActive` and `filterClr` are never high together in any pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal master clock |
| rstN | input | 1 | Asynchronous active-low reset and power-down |
| lrClkIn | input | 1 | Left/right framing clock, asynchronous |
| wordClkIn | input | 1 | Word clock when it is an input, asynchronous |
| slaveMode | input | 1 | 1: framing slave, 0: framing master |
| wcInMode | input | 1 | 1: word clock input positions the data (slave only) |
| polSel | input | 1 | Bit clock polarity select |
| runEn | output | 1 | Conversion data output enabled |
| calActive | output | 1 | Offset calibration window open |
| outForce | output | 1 | Force serial outputs to their reset levels |
| filterClr | output | 1 | Clear decimation filter and output buffer |
| bitClkHold | output | 1 | Level for the bit clock while forced |

## Verification
On every cycle the assertions check the output relations: the forced reset state, the bit-clock rest level, the mutual exclusion of run, calibration and clear, run being sticky and unforced, and run being entered only from calibration. The bench's scenarios show the sequencing: the three-edge reset release, the exact calibration length in framing periods, the rejection of a premature rise or a wrong level order, and a restart after an abort mid-calibration. These scenarios depend on ordered history that a single-cycle property cannot express. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;

  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_WAIT_FALL,
    ST_WAIT_RISE,
    ST_SEQ_A,
    ST_SEQ_B,
    ST_SEQ_C,
    ST_CAL,
    ST_RUN
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic cntEn;
    logic filtClr;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic lrRise;
    logic lrFall;
    logic lrLvl;
    logic wcLvl;
    logic calDone;
  } dpFlags_t;

endpackage

// File: rtl/startup_seq_sync.sv
module startup_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/startup_seq_dp.sv
module startup_seq_dp
  import startup_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CAL_PERIODS = 8192
) (
  input  logic        clk,
  input  logic        rstRawN,
  input  logic        lrClkIn,
  input  logic        wordClkIn,
  input  ctrlStrobe_t strobe,
  output logic        rstSyncN,
  output logic        filterClr,
  output dpFlags_t    flags
);
  localparam int NUM_IN = 2;
  localparam int CNT_W  = $clog2(CAL_PERIODS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CAL_PERIODS - 1);

  logic [NUM_IN-1:0] rawIn, syncIn;
  logic              lrPrev;
  logic [CNT_W-1:0]  periodCnt;

  assign rawIn = {wordClkIn, lrClkIn};

  // Reset release synchroniser; assertion stays asynchronous.
  startup_seq_sync #(.STAGES(SYNC_STAGES)) u_rstSync (
    .clk (clk),
    .rstN(rstRawN),
    .d   (1'b1),
    .q   (rstSyncN)
  );

  // Framing input synchronisers fill while reset release is in flight.
  generate
    for (genvar g = 0; g < NUM_IN; g++) begin : g_inSync
      startup_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rstN(rstRawN),
        .d   (rawIn[g]),
        .q   (syncIn[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rstSyncN) begin
    if (!rstSyncN) lrPrev <= 1'b0;
    else           lrPrev <= syncIn[0];
  end

  always_ff @(posedge clk or negedge rstSyncN) begin
    if (!rstSyncN)          periodCnt <= '0;
    else if (!strobe.cntEn) periodCnt <= '0;
    else if (flags.lrRise)  periodCnt <= periodCnt + 1'b1;
  end

  always_comb begin
    flags.lrLvl   = syncIn[0];
    flags.wcLvl   = syncIn[1];
    flags.lrRise  = syncIn[0] & ~lrPrev;
    flags.lrFall  = ~syncIn[0] & lrPrev;
    flags.calDone = strobe.cntEn & flags.lrRise & (periodCnt == LAST_CNT);
  end

  assign filterClr = ~rstSyncN | strobe.filtClr;
endmodule

// File: rtl/startup_seq_ctrl.sv
module startup_seq_ctrl
  import startup_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstSyncN,
  input  logic        slaveMode,
  input  logic        wcInMode,
  input  dpFlags_t    flags,
  output ctrlStrobe_t strobe,
  output logic        runEn,
  output logic        calActive
);
  seqState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstSyncN) begin
    if (!rstSyncN) stateQ <= ST_CLEAR;
    else           stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_CLEAR: begin
        if (!slaveMode)    stateD = ST_CAL;
        else if (wcInMode) stateD = ST_SEQ_A;
        else               stateD = ST_WAIT_FALL;
      end
      ST_WAIT_FALL: if (flags.lrFall) stateD = ST_WAIT_RISE;
      ST_WAIT_RISE: if (flags.lrRise) stateD = ST_CAL;
      ST_SEQ_A:     if (flags.wcLvl &  flags.lrLvl) stateD = ST_SEQ_B;
      ST_SEQ_B:     if (flags.wcLvl & ~flags.lrLvl) stateD = ST_SEQ_C;
      ST_SEQ_C:     if (flags.wcLvl &  flags.lrLvl) stateD = ST_CAL;
      ST_CAL:       if (flags.calDone) stateD = ST_RUN;
      ST_RUN:       stateD = ST_RUN;
      default:      stateD = ST_CLEAR;
    endcase
  end

  always_comb begin
    strobe.filtClr = (stateQ == ST_CLEAR);
    strobe.cntEn   = (stateQ == ST_CAL);
    calActive      = (stateQ == ST_CAL);
    runEn          = (stateQ == ST_RUN);
  end
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import startup_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CAL_PERIODS = 8192
) (
  input  logic clk,
  input  logic rstN,
  input  logic lrClkIn,
  input  logic wordClkIn,
  input  logic slaveMode,
  input  logic wcInMode,
  input  logic polSel,
  output logic runEn,
  output logic calActive,
  output logic outForce,
  output logic filterClr,
  output logic bitClkHold
);
  ctrlStrobe_t strobe;
  dpFlags_t    flags;
  logic        rstSyncN;

  startup_seq_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .CAL_PERIODS(CAL_PERIODS)
  ) u_dp (
    .clk      (clk),
    .rstRawN  (rstN),
    .lrClkIn  (lrClkIn),
    .wordClkIn(wordClkIn),
    .strobe   (strobe),
    .rstSyncN (rstSyncN),
    .filterClr(filterClr),
    .flags    (flags)
  );

  startup_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstSyncN (rstSyncN),
    .slaveMode(slaveMode),
    .wcInMode (wcInMode),
    .flags    (flags),
    .strobe   (strobe),
    .runEn    (runEn),
    .calActive(calActive)
  );

  assign outForce   = ~runEn;
  assign bitClkHold = outForce & polSel;
endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk (
  input logic clk,
  input logic rstN,
  input logic polSel,
  input logic runEn,
  input logic calActive,
  input logic outForce,
  input logic filterClr,
  input logic bitClkHold
);
  always @(negedge clk) begin
    if (rstN === 1'b0)
      AST_RESET_FORCE: assert (!runEn && !calActive && outForce && filterClr); // R1
  end

  AST_HOLD_POL: assert property (@(posedge clk) disable iff (!rstN)
    outForce |-> (bitClkHold == polSel)); // R2

  AST_EXCL_RUN_CAL: assert property (@(posedge clk) disable iff (!rstN)
    !(runEn && calActive)); // R11

  AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    filterClr |-> (!runEn && !calActive)); // R11

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    runEn |=> runEn); // R10

  AST_RUN_UNFORCED: assert property (@(posedge clk) disable iff (!rstN)
    runEn |-> !outForce); // R10

  AST_RUN_AFTER_CAL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runEn) |-> $past(calActive)); // R8
endmodule

bind startup_seq startup_seq_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .polSel    (polSel),
  .runEn     (runEn),
  .calActive (calActive),
  .outForce  (outForce),
  .filterClr (filterClr),
  .bitClkHold(bitClkHold)
);

// File: tb/startup_seq_tb_top.sv
module startup_seq_tb_top;
  localparam int CAL = 8192;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic lrPin = 1'b0, wcPin = 1'b0, slavePin = 1'b0, wcModePin = 1'b0, polPin = 1'b1;
  logic runEn, calActive, outForce, filterClr, bitClkHold;

  int  checkCnt = 0, failCnt = 0;
  bit  started = 0, lrRun = 0, finished = 0;
  int  lrPhase = 0;

  always #5 clk = ~clk;

  startup_seq dut_i (
    .clk(clk), .rstN(rstN), .lrClkIn(lrPin), .wordClkIn(wcPin),
    .slaveMode(slavePin), .wcInMode(wcModePin), .polSel(polPin),
    .runEn(runEn), .calActive(calActive), .outForce(outForce),
    .filterClr(filterClr), .bitClkHold(bitClkHold)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // Left/right clock generator: period of 4 clocks, changes 2 ns after an edge.
  always @(posedge clk) begin
    #2;
    if (lrRun) begin
      lrPhase = (lrPhase + 1) % 4;
      lrPin   = (lrPhase < 2);
    end
  end

  // Behavioural reference model: histories of pin samples and a phase number.
  // phase 0 clear, 1 wait fall, 2 wait rise, 3..5 level order, 6 calibrate, 7 run
  bit [1:0] mRst = '0, mLrQ = '0, mWcQ = '0;
  bit       mPrev = 0;
  int       mPhase = 0, mCount = 0;

  always @(negedge rstN) begin
    mRst = '0; mLrQ = '0; mWcQ = '0; mPrev = 0; mPhase = 0; mCount = 0;
  end

  always @(posedge clk) begin
    bit oSync, oLr, oWc, oPrev, rise, fall;
    if (rstN === 1'b1) begin
      oSync = mRst[1]; oLr = mLrQ[1]; oWc = mWcQ[1]; oPrev = mPrev;
      mRst = {mRst[0], 1'b1};
      mLrQ = {mLrQ[0], lrPin};
      mWcQ = {mWcQ[0], wcPin};
      if (oSync) begin
        rise = oLr && !oPrev;
        fall = !oLr && oPrev;
        case (mPhase)
          0: begin mCount = 0; mPhase = !slavePin ? 6 : (wcModePin ? 3 : 1); end
          1: if (fall) mPhase = 2;
          2: if (rise) mPhase = 6;
          3: if (oWc && oLr)  mPhase = 4;
          4: if (oWc && !oLr) mPhase = 5;
          5: if (oWc && oLr)  mPhase = 6;
          6: if (rise) begin
               if (mCount == CAL - 1) mPhase = 7;
               else mCount++;
             end
          default: ;
        endcase
        mPrev = oLr;
      end
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    bit eRun, eCal, eForce, eClr, eHold;
    if (started && !finished) begin
      eRun   = (mPhase == 7);
      eCal   = (mPhase == 6);
      eForce = !eRun;
      eClr   = !mRst[1] || (mPhase == 0);
      eHold  = eForce && polPin;
      chk(runEn == eRun, "R8", "runEn", runEn, eRun);
      chk(calActive == eCal, "R4", "calActive", calActive, eCal);
      chk(outForce == eForce, "R10", "outForce", outForce, eForce);
      chk(filterClr == eClr, "R3", "filterClr", filterClr, eClr);
      chk(bitClkHold == eHold, "R2", "bitClkHold", bitClkHold, eHold);
      chk(!(runEn && calActive) && !(filterClr && (runEn || calActive)),
          "R11", "exclusive", {runEn, calActive, filterClr}, 0);
    end
  end

  task automatic pulseResetLow();
    @(posedge clk); #2 rstN = 1'b0;
  endtask

  task automatic releaseReset();
    @(posedge clk); #2 rstN = 1'b1;
  endtask

  task automatic waitRun(output int calN);
    int n = 0;
    calN = 0;
    while (!runEn && n < 40000) begin
      @(negedge clk);
      if (calActive) calN++;
      n++;
    end
  endtask

  task automatic waitCal(output bit seen);
    seen = 0;
    for (int i = 0; i < 60 && !seen; i++) begin
      @(negedge clk);
      if (calActive) seen = 1;
    end
  endtask

  task automatic finish();
    finished = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  initial begin
    #(190000 * 10);
    checkCnt++; failCnt++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish();
  end

  initial begin
    int  calN;
    bit  seen;
    #1 rstN = 1'b0;
    started = 1;
    repeat (4) @(negedge clk);
    chk(!runEn && !calActive && outForce && filterClr, "R1", "reset state",
        {runEn, calActive, outForce, filterClr}, 4'b0011);
    chk(bitClkHold == 1'b1, "R2", "hold pol=1", bitClkHold, 1);
    polPin = 1'b0;
    @(negedge clk);
    chk(bitClkHold == 1'b0, "R2", "hold pol=0", bitClkHold, 0);
    polPin = 1'b1;

    // Master mode
    lrRun = 1;
    releaseReset();
    repeat (3) @(negedge clk);
    chk(filterClr == 1'b1, "R3", "clear after 2 edges", filterClr, 1);
    @(negedge clk);
    chk(filterClr == 1'b0, "R3", "clear after 3 edges", filterClr, 0);
    chk(calActive == 1'b1, "R4", "master enters cal", calActive, 1);
    waitRun(calN);
    chk(runEn == 1'b1, "R8", "master run", runEn, 1);
    chk(calN >= CAL*4-8 && calN <= CAL*4+8, "R8", "cal length", calN, CAL*4);
    chk(outForce == 1'b0 && bitClkHold == 1'b0, "R10", "unforced when running",
        {outForce, bitClkHold}, 0);
    repeat (100) @(negedge clk);
    chk(runEn == 1'b1, "R10", "run sticky", runEn, 1);

    // Asynchronous reset, then abort mid-calibration
    pulseResetLow();
    #1;
    chk(!runEn && filterClr && outForce, "R1", "async reset", {runEn, filterClr, outForce}, 3);
    repeat (3) @(posedge clk);
    releaseReset();
    repeat (1000) @(negedge clk);
    chk(calActive == 1'b1, "R9", "in cal before abort", calActive, 1);
    pulseResetLow();
    repeat (2) @(negedge clk);
    chk(!calActive && !runEn, "R9", "abort", {calActive, runEn}, 0);
    releaseReset();
    waitRun(calN);
    chk(calN >= CAL*4-8 && calN <= CAL*4+8, "R9", "full recount", calN, CAL*4);

    // Slave mode, left/right clock only
    pulseResetLow();
    @(negedge clk);
    lrRun = 0; lrPin = 1'b0; slavePin = 1'b1; wcModePin = 1'b0;
    releaseReset();
    repeat (20) @(negedge clk);
    chk(!calActive && outForce, "R5", "slave idle", {calActive, outForce}, 1);
    lrPin = 1'b1;
    repeat (20) @(negedge clk);
    chk(!calActive && outForce, "R6", "rise without fall", {calActive, outForce}, 1);
    lrPhase = 0; lrRun = 1;
    waitCal(seen);
    chk(seen, "R5", "fall then rise starts cal", seen, 1);
    waitRun(calN);
    chk(runEn && calN >= CAL*4-8, "R8", "slave cal length", calN, CAL*4);

    // Slave mode with word clock input
    pulseResetLow();
    @(negedge clk);
    wcModePin = 1'b1; wcPin = 1'b0;
    releaseReset();
    repeat (40) @(negedge clk);
    chk(!calActive, "R7", "word clock low holds", calActive, 0);
    lrRun = 0; lrPin = 1'b0; wcPin = 1'b1;
    repeat (20) @(negedge clk);
    chk(!calActive, "R7", "first state not seen", calActive, 0);
    lrPhase = 3; lrRun = 1;
    waitCal(seen);
    chk(seen, "R7", "ordered levels start cal", seen, 1);
    waitRun(calN);
    chk(runEn && calN >= CAL*4-8, "R8", "wc mode cal length", calN, CAL*4);

    repeat (5) @(negedge clk);
    finish();
  end
endmodule